// File: doc/BRIEF.md
# Precedence Window Assertion Monitor

This block is a synthesizable runtime checker for one temporal rule over three single-bit signals taken from the design it watches. When the trigger input is high in a cycle, an obligation opens on the following clock edge. From then on an acknowledge must be seen strictly before any error. An error in the same cycle as the acknowledge breaks the rule. An acknowledge discharges the obligation. An error while the obligation is open raises a one-cycle violation pulse and also closes the obligation.

The rule is checked on every cycle and re-arms each time the trigger is high. A trigger that comes while an obligation is already open does not create a second, separate obligation; it folds into the one that is open. A trigger in the same cycle as a discharge or a violation opens a new window on the next cycle. The obligation is weak: a window that never sees an acknowledge or an error never fails. A sticky flag records that any violation has occurred and is cleared only by the synchronous reset.

The control is a two-state machine. `PW_IDLE` means no obligation is open. `PW_WATCH` means an obligation is open. Its transitions are: ARM (`PW_IDLE` to `PW_WATCH` on trigger), HOLD (`PW_IDLE` stays when there is no trigger), MERGE (`PW_WATCH` stays on trigger, whatever else is high), CLOSE (`PW_WATCH` to `PW_IDLE` on acknowledge or error without trigger) and WAIT (`PW_WATCH` stays when all three inputs are low). The pulse and pending outputs are decoded from the state and the current inputs. The sticky flag is a register.

Top module: `prec_window_mon`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the state returns to `PW_IDLE` and `viol_sticky` clears. After reset, `obl_pending`, `viol_pulse` and `viol_sticky` are all 0 while the inputs stay low.
- R2: A rising edge with `trig_in` high makes `obl_pending` read 1 in the next cycle. `ack_in` and `err_in` in the trigger cycle itself do not affect that obligation.
- R3: While `obl_pending` is 1, `err_in` high makes `viol_pulse` 1 in that same cycle.
- R4: While `obl_pending` is 1, `ack_in` and `err_in` high together count as a violation, so `viol_pulse` is 1.
- R5: While `obl_pending` is 1, `ack_in` high with `err_in` and `trig_in` low discharges the obligation. `obl_pending` is 0 in the next cycle, and a later `err_in` gives no pulse.
- R6: An open obligation that sees neither `ack_in` nor `err_in` stays pending for any number of cycles and never raises `viol_pulse`.
- R7: A `trig_in` while `obl_pending` is 1 keeps one merged obligation. A single error then gives exactly one pulse, and `obl_pending` drops after it.
- R8: A `trig_in` in the same cycle as a discharge or a violation opens a fresh window, so `obl_pending` is 1 in the next cycle.
- R9: `viol_sticky` becomes 1 in the cycle after any `viol_pulse` and stays 1 until reset.
- R10: `viol_pulse` is never 1 while `obl_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock on which all inputs are sampled |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Trigger event that opens a window from the next cycle |
| ack_in | input | 1 | Acknowledge event that discharges an open window |
| err_in | input | 1 | Error event, a violation if seen while a window is open |
| viol_pulse | output | 1 | One-cycle violation indication, same cycle as the offending error |
| viol_sticky | output | 1 | Latched violation flag, cleared only by reset |
| obl_pending | output | 1 | High while an obligation is open |

## Verification
The hardest situations to reach from the ports are the overlaps: a trigger in the same cycle as a discharge or a violation, and repeated triggers inside an open window. Random inputs seldom put these in the right order. Directed sequences therefore build each overlap cycle by cycle, for example trigger, then acknowledge with trigger, then error. A long random phase follows. In that phase the trigger is biased high and acknowledge and error are biased low, so windows stay open long enough for merges and same-cycle collisions to occur many times. Each cycle is compared against a bench reference of the rule.

// File: rtl/prec_window_pkg.sv
package prec_window_pkg;

    typedef enum logic [0:0] {
        PW_IDLE  = 1'b0,
        PW_WATCH = 1'b1
    } pw_state_e;

endpackage

// File: rtl/pw_state_fsm.sv
module pw_state_fsm
    import prec_window_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trig_in,
    input  logic      ack_in,
    input  logic      err_in,
    output pw_state_e state_q,
    output logic      open_q,
    output logic      violate
);

    pw_state_e state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE: begin
                // ARM or HOLD
                state_d = trig_in ? PW_WATCH : PW_IDLE;
            end
            PW_WATCH: begin
                if (trig_in) begin
                    state_d = PW_WATCH;          // MERGE (also re-arm)
                end else if (ack_in || err_in) begin
                    state_d = PW_IDLE;           // CLOSE
                end else begin
                    state_d = PW_WATCH;          // WAIT
                end
            end
            default: state_d = PW_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // state-decoded outputs
    always_comb begin
        open_q  = 1'b0;
        violate = 1'b0;
        unique case (state_q)
            PW_IDLE: begin
                open_q  = 1'b0;
                violate = 1'b0;
            end
            PW_WATCH: begin
                open_q  = 1'b1;
                violate = err_in;                // error wins over ack
            end
            default: begin
                open_q  = 1'b0;
                violate = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pw_verdict.sv
module pw_verdict (
    input  logic clk,
    input  logic rst,
    input  logic violate,
    output logic pulse,
    output logic sticky_q
);

    assign pulse = violate;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= 1'b0;
        end else if (violate) begin
            sticky_q <= 1'b1;
        end
    end

endmodule

// File: rtl/prec_window_mon.sv
module prec_window_mon
    import prec_window_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    input  logic ack_in,
    input  logic err_in,
    output logic viol_pulse,
    output logic viol_sticky,
    output logic obl_pending
);

    pw_state_e state_q;
    logic      open_q;
    logic      violate;

    pw_state_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .trig_in (trig_in),
        .ack_in  (ack_in),
        .err_in  (err_in),
        .state_q (state_q),
        .open_q  (open_q),
        .violate (violate)
    );

    pw_verdict u_verdict (
        .clk      (clk),
        .rst      (rst),
        .violate  (violate),
        .pulse    (viol_pulse),
        .sticky_q (viol_sticky)
    );

    assign obl_pending = open_q;

endmodule

// File: rtl/pw_checks.sv
module pw_checks (
    input logic clk,
    input logic rst,
    input logic trig_in,
    input logic ack_in,
    input logic err_in,
    input logic viol_pulse,
    input logic viol_sticky,
    input logic obl_pending
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!obl_pending && !viol_sticky)); // R1

    AST_TRIG_OPENS: assert property (@(posedge clk) disable iff (rst)
        trig_in |=> obl_pending); // R2

    AST_ERR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (obl_pending && err_in) |-> viol_pulse); // R3

    AST_BOTH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (obl_pending && err_in && ack_in) |-> viol_pulse); // R4

    AST_ACK_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (obl_pending && ack_in && !err_in && !trig_in) |=> !obl_pending); // R5

    AST_QUIET_WAITS: assert property (@(posedge clk) disable iff (rst)
        (obl_pending && !ack_in && !err_in) |=> obl_pending); // R6

    AST_MERGE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (obl_pending && trig_in) |=> obl_pending); // R7

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |=> viol_sticky); // R9

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        viol_sticky |=> viol_sticky); // R9

    AST_NO_IDLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        !obl_pending |-> !viol_pulse); // R10

endmodule

bind prec_window_mon pw_checks u_pw_checks (
    .clk         (clk),
    .rst         (rst),
    .trig_in     (trig_in),
    .ack_in      (ack_in),
    .err_in      (err_in),
    .viol_pulse  (viol_pulse),
    .viol_sticky (viol_sticky),
    .obl_pending (obl_pending)
);

// File: tb/test_prec_window_mon.sv
`timescale 1ns/1ps
module test_prec_window_mon;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig_in = 1'b0;
    logic ack_in = 1'b0;
    logic err_in = 1'b0;
    logic viol_pulse;
    logic viol_sticky;
    logic obl_pending;

    int total = 0;
    int bad = 0;
    bit m_pend = 1'b0;
    bit m_sticky = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    prec_window_mon i_prec_window_mon (
        .clk         (clk),
        .rst         (rst),
        .trig_in     (trig_in),
        .ack_in      (ack_in),
        .err_in      (err_in),
        .viol_pulse  (viol_pulse),
        .viol_sticky (viol_sticky),
        .obl_pending (obl_pending)
    );

    // reference of the rule
    function automatic bit exp_pulse(bit pend, bit e);
        return pend && e;
    endfunction

    function automatic bit next_pend(bit r, bit pend, bit t, bit a, bit e);
        if (r) return 1'b0;
        return t || (pend && !a && !e);
    endfunction

    function automatic bit next_sticky(bit r, bit st, bit p);
        if (r) return 1'b0;
        return st || p;
    endfunction

    task automatic check(string tag, string what, bit act, bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, check just before posedge, update model at posedge
    task automatic step(bit r, bit t, bit a, bit e, string tag);
        bit p;
        @(negedge clk);
        rst = r; trig_in = t; ack_in = a; err_in = e;
        #3;
        p = exp_pulse(m_pend, e);
        check(tag, "viol_pulse", viol_pulse, p);
        check(tag, "obl_pending", obl_pending, m_pend);
        check(tag, "viol_sticky", viol_sticky, m_sticky);
        @(posedge clk);
        m_sticky = next_sticky(r, m_sticky, p);
        m_pend   = next_pend(r, m_pend, t, a, e);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));

        // R1 reset state
        step(1, 0, 0, 0, "R1");
        step(1, 1, 0, 1, "R1");
        step(0, 0, 0, 0, "R1");
        check("R1", "pending after reset", obl_pending, 1'b0);

        // R2 trigger-cycle error ignored, window opens next cycle
        step(0, 1, 0, 1, "R2");
        step(0, 0, 0, 0, "R2");
        // R3 error inside window
        step(0, 0, 0, 1, "R3");
        step(0, 0, 0, 0, "R3");

        // R4 ack and error together
        step(1, 0, 0, 0, "R4");
        step(0, 1, 0, 0, "R4");
        step(0, 0, 1, 1, "R4");
        step(0, 0, 0, 0, "R4");

        // R5 discharge, then later error is harmless
        step(1, 0, 0, 0, "R5");
        step(0, 1, 0, 0, "R5");
        step(0, 0, 1, 0, "R5");
        step(0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, "R5");

        // R6 weak obligation
        step(0, 1, 0, 0, "R6");
        for (int i = 0; i < 20; i++) step(0, 0, 0, 0, "R6");

        // R7 merged triggers, one pulse only
        step(1, 0, 0, 0, "R7");
        step(0, 1, 0, 0, "R7");
        step(0, 1, 0, 0, "R7");
        step(0, 1, 0, 0, "R7");
        step(0, 0, 0, 1, "R7");
        step(0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, "R7");

        // R8 re-arm in the discharge cycle and in the violation cycle
        step(1, 0, 0, 0, "R8");
        step(0, 1, 0, 0, "R8");
        step(0, 1, 1, 0, "R8");
        step(0, 1, 0, 1, "R8");
        step(0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, "R8");

        // R9 sticky holds through idle cycles, cleared by reset
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, "R9");
        step(0, 0, 0, 0, "R9");

        // R10 errors while idle never pulse
        step(0, 0, 0, 1, "R10");
        step(0, 0, 1, 1, "R10");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit r, t, a, e;
            r = ($urandom_range(0, 199) == 0);
            t = ($urandom_range(0, 99) < 30);
            a = ($urandom_range(0, 99) < 15);
            e = ($urandom_range(0, 99) < 12);
            step(r, t, a, e, "RND");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule